// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in without a rippling carry chain. Each bit position forms a generate term (both operand bits set) and a propagate term (either operand bit set). Every four bits form a group that reduces its local terms to one group generate and one group propagate. A second rank of the same four-input lookahead unit turns the group terms and the external carry-in into the carry entering each group. Each group then forms its own internal carries from its local terms. Every carry therefore passes through about two levels of small gates, not a chain as long as the operand.

The default width is 16 bits: four groups and one second-rank unit. At 32 bits there are eight groups feeding two second-rank units, and a third-rank unit sits above them. Widths up to 64 bits are supported. The adder logic is purely combinational. Its results go into one output register stage with a synchronous, active-high reset. Each result therefore appears on the clock edge after its operands are presented.

The block also reports the top-level propagate and generate for the whole word. A wider lookahead tree can then use this adder as one of its leaves.

Top module: `cla_adder_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, `sum`, `cout`, `grp_p` and `grp_g` are all 0 after that edge, whatever the operand inputs are.
- R2: After a rising edge with `rst` low, `sum` equals the low WIDTH bits of `a + b + cin`, taken from the values present at that edge.
- R3: After the same edge, `cout` equals bit WIDTH (the carry out) of `a + b + cin`.
- R4: `grp_p` is 1 exactly when every bit position has at least one operand bit set, so propagate is the OR of the two operand bits.
- R5: `grp_g` is 1 exactly when `a + b` with a carry-in of 0 overflows WIDTH bits.
- R6: `cout` always equals `grp_g | (grp_p & cin)`, using the `cin` of the same edge.
- R7: All-propagate case: with `a ^ b` all ones and `cin` = 1, the carry travels the whole word, so `sum` = 0, `cout` = 1, `grp_p` = 1 and `grp_g` = 0.
- R8: Generate-in-bit-0 case: with `a` = 1 and `b` all ones, the carry born in bit 0 reaches the top, so `sum` = 0, `cout` = 1, `grp_p` = 1 and `grp_g` = 1.
- R9: At a width of 32, carries cross between the two second-rank units through the third rank. R2 to R8 hold there unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |
| grp_p | output | 1 | Registered word-level propagate |
| grp_g | output | 1 | Registered word-level generate |

## Verification
On every cycle, the assertions compare the registered sum, carry out and word-level propagate and generate against the operands of the previous edge. They also check that the carry out agrees with the generate, propagate and carry-in. They cannot show that a carry really crosses every group and unit boundary. Only the bench's patterns can show that. Those are the byte sweep with a long propagate chain above it, the all-propagate and bit-0-generate cases, and the 32-bit instance, whose carries pass through the third rank.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GRP_W = 4;

  function automatic int units_for(input int n);
    return (n + GRP_W - 1) / GRP_W;
  endfunction
endpackage

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
  input  logic [3:0] g,
  input  logic [3:0] p,
  input  logic       cin,
  output logic [3:0] c,
  output logic       gg,
  output logic       gp
);
  always_comb begin
    c[0] = cin;
    c[1] = g[0] | (p[0] & cin);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & cin);
    gp   = p[0] & p[1] & p[2] & p[3];
    gg   = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
  end
endmodule

// File: rtl/cla_group4.sv
module cla_group4 (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output logic       gg,
  output logic       gp
);
  logic [3:0] bit_g, bit_p, carry;

  assign bit_g = a & b;
  assign bit_p = a | b;

  cla_lookahead4 la_i (
    .g(bit_g), .p(bit_p), .cin(cin), .c(carry), .gg(gg), .gp(gp)
  );

  assign sum = a ^ b ^ carry;
endmodule

// File: rtl/cla_adder_top.sv
module cla_adder_top #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             grp_p,
  output logic             grp_g
);
  import cla_pkg::*;

  localparam int NGRP = WIDTH / GRP_W;
  localparam int NU2  = units_for(NGRP);
  localparam int NPAD = NU2 * GRP_W;

  logic [NPAD-1:0]  grp_gg, grp_gp, grp_cin;
  logic [NU2-1:0]   u2_gg, u2_gp, u2_cin;
  logic [WIDTH-1:0] sum_c;
  logic             top_g, top_p;

  genvar k;
  generate
    for (k = 0; k < NPAD; k++) begin : g_grp
      if (k < NGRP) begin : g_real
        cla_group4 grp_i (
          .a(a[k*GRP_W +: GRP_W]), .b(b[k*GRP_W +: GRP_W]), .cin(grp_cin[k]),
          .sum(sum_c[k*GRP_W +: GRP_W]), .gg(grp_gg[k]), .gp(grp_gp[k])
        );
      end else begin : g_pad
        assign grp_gg[k] = 1'b0;
        assign grp_gp[k] = 1'b1;
      end
    end

    for (k = 0; k < NU2; k++) begin : g_u2
      cla_lookahead4 u2_i (
        .g(grp_gg[k*GRP_W +: GRP_W]), .p(grp_gp[k*GRP_W +: GRP_W]), .cin(u2_cin[k]),
        .c(grp_cin[k*GRP_W +: GRP_W]), .gg(u2_gg[k]), .gp(u2_gp[k])
      );
    end

    if (NU2 == 1) begin : g_two_rank
      assign u2_cin[0] = cin;
      assign top_g     = u2_gg[0];
      assign top_p     = u2_gp[0];
    end else begin : g_three_rank
      logic [3:0] l3_g, l3_p, l3_c;
      for (k = 0; k < 4; k++) begin : g_l3_in
        if (k < NU2) begin : g_use
          assign l3_g[k]   = u2_gg[k];
          assign l3_p[k]   = u2_gp[k];
          assign u2_cin[k] = l3_c[k];
        end else begin : g_fill
          assign l3_g[k] = 1'b0;
          assign l3_p[k] = 1'b1;
        end
      end
      cla_lookahead4 u3_i (
        .g(l3_g), .p(l3_p), .cin(cin), .c(l3_c), .gg(top_g), .gp(top_p)
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sum   <= '0;
      cout  <= 1'b0;
      grp_p <= 1'b0;
      grp_g <= 1'b0;
    end else begin
      sum   <= sum_c;
      cout  <= top_g | (top_p & cin);
      grp_p <= top_p;
      grp_g <= top_g;
    end
  end
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic             grp_p,
  input logic             grp_g
);
  logic [WIDTH:0] full_w_cin, full_no_cin;
  logic           all_prop;

  assign full_w_cin  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  assign full_no_cin = {1'b0, a} + {1'b0, b};
  assign all_prop    = &(a | b);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (sum == '0 && !cout && !grp_p && !grp_g));

  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sum == $past(full_w_cin[WIDTH-1:0]));

  p_cout_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cout == $past(full_w_cin[WIDTH]));

  p_grp_p_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> grp_p == $past(all_prop));

  p_grp_g_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> grp_g == $past(full_no_cin[WIDTH]));

  p_cout_comp_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cout == (grp_g | (grp_p & $past(cin))));
endmodule

bind cla_adder_top cla_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
  .sum(sum), .cout(cout), .grp_p(grp_p), .grp_g(grp_g)
);

// File: tb/cla_adder_top_tb_top.sv
module cla_adder_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a16 = '0, b16 = '0, sum16;
  logic [31:0] a32 = '0, b32 = '0, sum32;
  logic        cin = 1'b0;
  logic        cout16, p16, g16, cout32, p32, g32;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cla_adder_top #(.WIDTH(16)) dut_i (
    .clk(clk), .rst(rst), .a(a16), .b(b16), .cin(cin),
    .sum(sum16), .cout(cout16), .grp_p(p16), .grp_g(g16)
  );

  cla_adder_top #(.WIDTH(32)) dut32_i (
    .clk(clk), .rst(rst), .a(a32), .b(b32), .cin(cin),
    .sum(sum32), .cout(cout32), .grp_p(p32), .grp_g(g32)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge,
  // sample at the following falling edge
  task automatic apply(input logic [15:0] x16, input logic [15:0] y16,
                       input logic [31:0] x32, input logic [31:0] y32, input logic ci);
    logic [16:0] e16, n16;
    logic [32:0] e32, n32;
    @(negedge clk);
    a16 = x16; b16 = y16; a32 = x32; b32 = y32; cin = ci;
    e16 = {1'b0, x16} + {1'b0, y16} + {16'd0, ci};
    n16 = {1'b0, x16} + {1'b0, y16};
    e32 = {1'b0, x32} + {1'b0, y32} + {32'd0, ci};
    n32 = {1'b0, x32} + {1'b0, y32};
    @(negedge clk);
    chk("R2 sum16", 64'(sum16), 64'(e16[15:0]));
    chk("R3 cout16", 64'(cout16), 64'(e16[16]));
    chk("R4 p16", 64'(p16), 64'(&(x16 | y16)));
    chk("R5 g16", 64'(g16), 64'(n16[16]));
    chk("R6 compose16", 64'(cout16), 64'(g16 | (p16 & ci)));
    chk("R9 sum32", 64'(sum32), 64'(e32[31:0]));
    chk("R9 cout32", 64'(cout32), 64'(e32[32]));
    chk("R9 p32", 64'(p32), 64'(&(x32 | y32)));
    chk("R9 g32", 64'(g32), 64'(n32[32]));
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst = 1'b1; a16 = 16'hFFFF; b16 = 16'h0001; a32 = '1; b32 = 32'd1; cin = 1'b1;
    @(negedge clk);
    chk("R1 sum16", 64'(sum16), 64'd0);
    chk("R1 flags16", 64'({cout16, p16, g16}), 64'd0);
    chk("R1 sum32", 64'(sum32), 64'd0);
    chk("R1 flags32", 64'({cout32, p32, g32}), 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    reset_check();

    // R7: all-propagate, carry-in 1
    apply(16'hFFFF, 16'h0000, 32'hFFFF_FFFF, 32'h0, 1'b1);
    chk("R7 sum16", 64'(sum16), 64'd0);
    chk("R7 flags16", 64'({cout16, p16, g16}), 64'b110);
    chk("R7 flags32", 64'({cout32, p32, g32}), 64'b110);
    apply(16'h5555, 16'hAAAA, 32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    chk("R7 alt sum32", 64'(sum32), 64'd0);
    // R8: generate in bit 0, all others propagate
    apply(16'h0001, 16'hFFFF, 32'h1, 32'hFFFF_FFFF, 1'b0);
    chk("R8 sum16", 64'(sum16), 64'd0);
    chk("R8 flags16", 64'({cout16, p16, g16}), 64'b111);
    chk("R8 flags32", 64'({cout32, p32, g32}), 64'b111);
    // all zeros
    apply(16'h0, 16'h0, 32'h0, 32'h0, 1'b0);
    chk("R2 zero", 64'({cout16, p16, g16, sum16}), 64'd0);

    // byte sweep with a propagate chain above it (R2..R6, R9)
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 3) begin
        apply({8'hFF, 8'(i)}, {8'h00, 8'(j)},
              {24'hFF_FFFF, 8'(i)}, {24'h0, 8'(j)}, 1'((i ^ j) & 1));
      end
    end

    reset_check();

    for (int n = 0; n < 5000; n++) begin
      apply(16'($urandom), 16'($urandom), $urandom, $urandom, 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule